// File: doc/BRIEF.md
# DRAM Command Spacing Tracker

This block sits beside a DRAM command scheduler. It watches every command that the scheduler issues and answers one question each clock: may a READ, or a WRITE, to the rank and bank on the query port go out in this DRAM clock? Four programmable minimum gaps are enforced, all counted in DRAM clocks:

- ACTIVATE to READ and ACTIVATE to WRITE, each tracked for every rank-bank pair.
- WRITE to WRITE and WRITE to READ, each tracked for every rank, so any bank of that rank is affected.

A fifth value holds READs back for a programmed time after the read-strobe delay lines are switched on. The delay lines are announced by a one-cycle enable pulse.

Each constraint is kept by a small gap timer. A gap timer has two states:

- `GT_READY`: the gap has elapsed.
- `GT_WAIT`: a countdown is running.

It has three transitions:

- *arm*: a matching event with a gap of 2 or more moves the timer to `GT_WAIT` with a count of gap−1. This also restarts a timer that is already in `GT_WAIT`.
- *tick*: in `GT_WAIT`, a count above 1 is decremented.
- *expire*: in `GT_WAIT`, a count of 1 returns the timer to `GT_READY`.

A matching event with a gap of 0 or 1 leaves the timer in `GT_READY`. Both flags are combinational from the timer states. A command issued in a given cycle therefore changes the flags only from the next cycle onward.

Top module: `dram_spacing_tracker`

## Requirements

- R1: After reset every timing field reads back as zero, and both `rd_ok` and `wr_ok` are high for every rank and bank.
- R2: Register 0 holds WRITE→WRITE in bits [3:0], WRITE→READ in bits [7:4] and ACTIVATE→WRITE in bits [11:8]. Register 1 holds ACTIVATE→READ in bits [3:0] and the delay-line read-safe wait in bits [10:8]. All other bits read as zero and ignore writes.
- R3: If an ACTIVATE (`cmd_type`=1) issues to rank r, bank b in cycle t with ACTIVATE→WRITE gap N, then `wr_ok` for (r,b) is low in cycles t+1 to t+N−1 and high again from t+N. Other rank-bank pairs are not affected.
- R4: The same rule holds for ACTIVATE→READ, acting on `rd_ok` of the same rank-bank only.
- R5: A WRITE (`cmd_type`=3) issued to rank r in cycle t with WRITE→WRITE gap N holds `wr_ok` low for every bank of rank r in cycles t+1 to t+N−1. The other rank is not affected.
- R6: A WRITE issued to rank r in cycle t with WRITE→READ gap N holds `rd_ok` low for every bank of rank r in cycles t+1 to t+N−1.
- R7: A `dll_en` pulse in cycle t with read-safe wait N holds `rd_ok` low for all ranks and banks in cycles t+1 to t+N−1. `wr_ok` is not affected.
- R8: A programmed gap of 0 or 1 never lowers a flag, so the following command may issue in the very next cycle.
- R9: A command or `dll_en` presented in a cycle does not change `rd_ok` or `wr_ok` in that same cycle.
- R10: A repeated event restarts its window from the latest issue.
- R11: READ (`cmd_type`=2) and NOP (`cmd_type`=0) commands, and any command while `cmd_valid` is low, lower no flag.

## Ports

| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | DRAM clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr_en | input | 1 | Register write strobe |
| cfg_addr | input | 1 | Register select (0 or 1) |
| cfg_wdata | input | 16 | Register write data |
| cfg_rdata | output | 16 | Register read data for `cfg_addr` |
| cmd_valid | input | 1 | A command issues this cycle |
| cmd_type | input | 2 | 0 NOP, 1 ACTIVATE, 2 READ, 3 WRITE |
| cmd_rank | input | 1 | Rank of the issued command |
| cmd_bank | input | 3 | Bank of the issued command |
| dll_en | input | 1 | Pulse: read-strobe delay lines enabled |
| req_rank | input | 1 | Rank of the proposed command |
| req_bank | input | 3 | Bank of the proposed command |
| rd_ok | output | 1 | A READ to (req_rank, req_bank) may issue now |
| wr_ok | output | 1 | A WRITE to (req_rank, req_bank) may issue now |

## Verification

The bench builds the block with its default 2 ranks of 8 banks. This is small enough that all 16 rank-bank pairs are queried on the request port in every cycle, and the result is compared with a model that keeps the last issue cycle of each event.

Random command streams are run under several fixed timing sets:

- all gaps zero;
- all gaps one;
- all fields at their maxima (15 and 7);
- mixed values.

Together these cover the no-wait corner, the longest windows, restarts of a running window, and the overlap of bank, rank and delay-line constraints. The flag for the issuing pair is also checked again after the command is driven and before the clock edge.

// File: rtl/dst_pkg.sv
package dst_pkg;
    localparam int CNT_W = 4;
    localparam int DLL_W = 3;
    localparam int REG_W = 16;

    typedef enum logic [1:0] {
        CMD_NOP = 2'd0,
        CMD_ACT = 2'd1,
        CMD_RD  = 2'd2,
        CMD_WR  = 2'd3
    } cmd_e;

    typedef struct packed {
        logic [CNT_W-1:0] act_wr;
        logic [CNT_W-1:0] act_rd;
        logic [CNT_W-1:0] wr_wr;
        logic [CNT_W-1:0] wr_rd;
        logic [DLL_W-1:0] dll_safe;
    } timing_cfg_t;
endpackage

// File: rtl/dst_cfg_regs.sv
module dst_cfg_regs
    import dst_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             addr,
    input  logic [REG_W-1:0] wdata,
    output logic [REG_W-1:0] rdata,
    output timing_cfg_t      cfg
);
    localparam int WWR_LO = 0;
    localparam int WRD_LO = WWR_LO + CNT_W;
    localparam int AWR_LO = WRD_LO + CNT_W;
    localparam int ARD_LO = 0;
    localparam int DLL_LO = 8;

    logic unused_wbits;
    assign unused_wbits = ^wdata[REG_W-1:AWR_LO+CNT_W];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg <= '0;
        end else if (wr_en) begin
            if (!addr) begin
                cfg.wr_wr  <= wdata[WWR_LO +: CNT_W];
                cfg.wr_rd  <= wdata[WRD_LO +: CNT_W];
                cfg.act_wr <= wdata[AWR_LO +: CNT_W];
            end else begin
                cfg.act_rd   <= wdata[ARD_LO +: CNT_W];
                cfg.dll_safe <= wdata[DLL_LO +: DLL_W];
            end
        end
    end

    always_comb begin
        rdata = '0;
        if (!addr) begin
            rdata[WWR_LO +: CNT_W] = cfg.wr_wr;
            rdata[WRD_LO +: CNT_W] = cfg.wr_rd;
            rdata[AWR_LO +: CNT_W] = cfg.act_wr;
        end else begin
            rdata[ARD_LO +: CNT_W] = cfg.act_rd;
            rdata[DLL_LO +: DLL_W] = cfg.dll_safe;
        end
    end

    AST_REG0_STORE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !addr) |=> (cfg.act_wr == $past(wdata[AWR_LO +: CNT_W]) && cfg.wr_wr == $past(wdata[WWR_LO +: CNT_W]))); // R2
    AST_REG1_STORE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr) |=> (cfg.dll_safe == $past(wdata[DLL_LO +: DLL_W]) && $stable(cfg.wr_rd))); // R2
endmodule

// File: rtl/dst_gap_timer.sv
module dst_gap_timer #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [W-1:0] limit,
    output logic         ready
);
    typedef enum logic {GT_READY, GT_WAIT} gt_state_e;

    gt_state_e    state_q, state_d;
    logic [W-1:0] rem_q, rem_d;

    always_comb begin
        state_d = state_q;
        rem_d   = rem_q;
        if (start) begin
            if (limit > W'(1)) begin
                state_d = GT_WAIT;
                rem_d   = limit - W'(1);
            end else begin
                state_d = GT_READY;
                rem_d   = '0;
            end
        end else begin
            unique case (state_q)
                GT_READY: begin
                    rem_d = '0;
                end
                GT_WAIT: begin
                    if (rem_q <= W'(1)) begin
                        state_d = GT_READY;
                        rem_d   = '0;
                    end else begin
                        rem_d = rem_q - W'(1);
                    end
                end
                default: begin
                    state_d = GT_READY;
                    rem_d   = '0;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= GT_READY;
            rem_q   <= '0;
        end else begin
            state_q <= state_d;
            rem_q   <= rem_d;
        end
    end

    always_comb begin
        ready = (state_q == GT_READY);
    end

    AST_SHORT_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        (start && limit <= W'(1)) |=> ready); // R8
    AST_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        (start && limit > W'(1)) |=> (!ready && rem_q == $past(limit) - W'(1))); // R10
    AST_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == GT_WAIT && !start) |=> (rem_q == $past(rem_q) - W'(1))); // R3
    AST_READY_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> (rem_q == '0)); // R1
endmodule

// File: rtl/dram_spacing_tracker.sv
module dram_spacing_tracker
    import dst_pkg::*;
#(
    parameter int RANKS = 2,
    parameter int BANKS = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cfg_wr_en,
    input  logic                     cfg_addr,
    input  logic [15:0]              cfg_wdata,
    output logic [15:0]              cfg_rdata,
    input  logic                     cmd_valid,
    input  logic [1:0]               cmd_type,
    input  logic [$clog2(RANKS)-1:0] cmd_rank,
    input  logic [$clog2(BANKS)-1:0] cmd_bank,
    input  logic                     dll_en,
    input  logic [$clog2(RANKS)-1:0] req_rank,
    input  logic [$clog2(BANKS)-1:0] req_bank,
    output logic                     rd_ok,
    output logic                     wr_ok
);
    localparam int RB_N = RANKS * BANKS;
    localparam int BK_W = $clog2(BANKS);
    localparam int IX_W = $clog2(RB_N);

    timing_cfg_t     cfg_q;
    logic [RB_N-1:0] act_rd_rdy, act_wr_rdy;
    logic [RANKS-1:0] wr_wr_rdy, wr_rd_rdy;
    logic            dll_rdy;
    logic            is_act, is_wr;
    logic [IX_W-1:0] req_ix;

    assign is_act = cmd_valid && (cmd_e'(cmd_type) == CMD_ACT);
    assign is_wr  = cmd_valid && (cmd_e'(cmd_type) == CMD_WR);
    assign req_ix = {req_rank, req_bank};

    dst_cfg_regs u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (cfg_wr_en),
        .addr  (cfg_addr),
        .wdata (cfg_wdata),
        .rdata (cfg_rdata),
        .cfg   (cfg_q)
    );

    for (genvar rb = 0; rb < RB_N; rb++) begin : g_bank
        logic hit;
        assign hit = is_act && (cmd_rank == (rb / BANKS)) && (cmd_bank == BK_W'(rb % BANKS));

        dst_gap_timer #(.W(CNT_W)) u_act_rd (
            .clk(clk), .rst_n(rst_n), .start(hit), .limit(cfg_q.act_rd), .ready(act_rd_rdy[rb])
        );
        dst_gap_timer #(.W(CNT_W)) u_act_wr (
            .clk(clk), .rst_n(rst_n), .start(hit), .limit(cfg_q.act_wr), .ready(act_wr_rdy[rb])
        );
    end

    for (genvar r = 0; r < RANKS; r++) begin : g_rank
        logic hit;
        assign hit = is_wr && (cmd_rank == r);

        dst_gap_timer #(.W(CNT_W)) u_wr_wr (
            .clk(clk), .rst_n(rst_n), .start(hit), .limit(cfg_q.wr_wr), .ready(wr_wr_rdy[r])
        );
        dst_gap_timer #(.W(CNT_W)) u_wr_rd (
            .clk(clk), .rst_n(rst_n), .start(hit), .limit(cfg_q.wr_rd), .ready(wr_rd_rdy[r])
        );
    end

    dst_gap_timer #(.W(DLL_W)) u_dll (
        .clk(clk), .rst_n(rst_n), .start(dll_en), .limit(cfg_q.dll_safe), .ready(dll_rdy)
    );

    always_comb begin
        rd_ok = act_rd_rdy[req_ix] && wr_rd_rdy[req_rank] && dll_rdy;
        wr_ok = act_wr_rdy[req_ix] && wr_wr_rdy[req_rank];
    end

    AST_ACT_WR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (is_act && cfg_q.act_wr > 4'd1 && req_rank == cmd_rank && req_bank == cmd_bank)
        |=> (req_rank != $past(req_rank) || req_bank != $past(req_bank) || !wr_ok)); // R3
    AST_ACT_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (is_act && cfg_q.act_rd > 4'd1 && req_rank == cmd_rank && req_bank == cmd_bank)
        |=> (req_rank != $past(req_rank) || req_bank != $past(req_bank) || !rd_ok)); // R4
    AST_WR_WR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (is_wr && cfg_q.wr_wr > 4'd1 && req_rank == cmd_rank)
        |=> (req_rank != $past(req_rank) || !wr_ok)); // R5
    AST_WR_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (is_wr && cfg_q.wr_rd > 4'd1 && req_rank == cmd_rank)
        |=> (req_rank != $past(req_rank) || !rd_ok)); // R6
    AST_DLL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (dll_en && cfg_q.dll_safe > 3'd1) |=> !rd_ok); // R7
endmodule

// File: tb/dram_spacing_tracker_test.sv
`timescale 1ns/100ps
module dram_spacing_tracker_test;
    localparam int RANKS = 2;
    localparam int BANKS = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr_en = 1'b0;
    logic        cfg_addr = 1'b0;
    logic [15:0] cfg_wdata = '0;
    logic [15:0] cfg_rdata;
    logic        cmd_valid = 1'b0;
    logic [1:0]  cmd_type = '0;
    logic        cmd_rank = 1'b0;
    logic [2:0]  cmd_bank = '0;
    logic        dll_en = 1'b0;
    logic        req_rank = 1'b0;
    logic [2:0]  req_bank = '0;
    logic        rd_ok, wr_ok;

    int tests = 0;
    int fails = 0;
    bit done = 1'b0;

    int cyc = 0;
    int last_act [RANKS][BANKS];
    int last_wr [RANKS];
    int last_dll;
    int n_awr, n_ard, n_ww, n_wrd, n_dll;

    always #2.5 clk = ~clk;

    dram_spacing_tracker uut (
        .clk(clk), .rst_n(rst_n),
        .cfg_wr_en(cfg_wr_en), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .cmd_valid(cmd_valid), .cmd_type(cmd_type), .cmd_rank(cmd_rank), .cmd_bank(cmd_bank),
        .dll_en(dll_en), .req_rank(req_rank), .req_bank(req_bank),
        .rd_ok(rd_ok), .wr_ok(wr_ok)
    );

    function automatic bit gap_ok(int since, int n);
        return since >= ((n < 1) ? 1 : n);
    endfunction

    function automatic bit exp_wr(int r, int b);
        return gap_ok(cyc - last_act[r][b], n_awr) && gap_ok(cyc - last_wr[r], n_ww);
    endfunction

    function automatic bit exp_rd(int r, int b);
        return gap_ok(cyc - last_act[r][b], n_ard) && gap_ok(cyc - last_wr[r], n_wrd)
            && gap_ok(cyc - last_dll, n_dll);
    endfunction

    task automatic check(string tag, int act, int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s cycle %0d: actual %0h expected %0h", tag, cyc, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        cyc++;
        #1;
    endtask

    task automatic query_pair(int r, int b, string tag);
        req_rank = r[0];
        req_bank = b[2:0];
        #0.1;
        check({tag, " wr_ok"}, wr_ok, exp_wr(r, b));
        check({tag, " rd_ok"}, rd_ok, exp_rd(r, b));
    endtask

    task automatic sweep_all(string tag);
        for (int r = 0; r < RANKS; r++)
            for (int b = 0; b < BANKS; b++)
                query_pair(r, b, tag);
    endtask

    task automatic cfg_write(bit a, logic [15:0] d);
        @(negedge clk);
        cfg_wr_en = 1'b1;
        cfg_addr  = a;
        cfg_wdata = d;
        tick();
        cfg_wr_en = 1'b0;
    endtask

    task automatic set_timing(int awr, int ard, int ww, int wrd, int dl);
        cfg_write(1'b0, 16'(((awr & 15) << 8) | ((wrd & 15) << 4) | (ww & 15)));
        cfg_write(1'b1, 16'(((dl & 7) << 8) | (ard & 15)));
        n_awr = awr; n_ard = ard; n_ww = ww; n_wrd = wrd; n_dll = dl;
        for (int i = 0; i < 20; i++) tick();
    endtask

    task automatic run_random(int ncyc, string tag);
        for (int i = 0; i < ncyc; i++) begin
            @(negedge clk);
            sweep_all({tag, " R3 R4 R5 R6 R7 R8 R10 R11"});
            cmd_valid = ($urandom % 4) != 0;
            cmd_type  = 2'($urandom % 4);
            cmd_rank  = 1'($urandom % RANKS);
            cmd_bank  = 3'($urandom % BANKS);
            dll_en    = ($urandom % 12) == 0;
            // R9: flags for the issuing pair unchanged in the issuing cycle
            query_pair(cmd_rank, cmd_bank, {tag, " R9"});
            @(posedge clk);
            if (cmd_valid && cmd_type == 2'd1) last_act[cmd_rank][cmd_bank] = cyc;
            if (cmd_valid && cmd_type == 2'd3) last_wr[cmd_rank] = cyc;
            if (dll_en) last_dll = cyc;
            cyc++;
            #1;
            cmd_valid = 1'b0;
            dll_en = 1'b0;
        end
        for (int i = 0; i < 20; i++) tick();
    endtask

    initial begin
        for (int r = 0; r < RANKS; r++) begin
            last_wr[r] = -1000;
            for (int b = 0; b < BANKS; b++) last_act[r][b] = -1000;
        end
        last_dll = -1000;
        n_awr = 0; n_ard = 0; n_ww = 0; n_wrd = 0; n_dll = 0;

        for (int i = 0; i < 4; i++) tick();
        rst_n = 1'b1;
        tick();

        // R1: reset state
        @(negedge clk);
        cfg_addr = 1'b0; #0.1;
        check("R1 reg0", cfg_rdata, 16'h0000);
        cfg_addr = 1'b1; #0.1;
        check("R1 reg1", cfg_rdata, 16'h0000);
        sweep_all("R1");

        // R2: field layout and reserved bits
        cfg_write(1'b0, 16'hFFFF);
        cfg_write(1'b1, 16'hFFFF);
        @(negedge clk);
        cfg_addr = 1'b0; #0.1;
        check("R2 reg0 mask", cfg_rdata, 16'h0FFF);
        cfg_addr = 1'b1; #0.1;
        check("R2 reg1 mask", cfg_rdata, 16'h070F);
        cfg_write(1'b0, 16'hA5C3);
        cfg_write(1'b1, 16'hF25E);
        @(negedge clk);
        cfg_addr = 1'b0; #0.1;
        check("R2 reg0 value", cfg_rdata, 16'h05C3);
        cfg_addr = 1'b1; #0.1;
        check("R2 reg1 value", cfg_rdata, 16'h020E);

        set_timing(0, 0, 0, 0, 0);
        run_random(300, "zero");
        set_timing(1, 1, 1, 1, 1);
        run_random(300, "one");
        set_timing(15, 15, 15, 15, 7);
        run_random(400, "max");
        set_timing(3, 5, 2, 7, 4);
        run_random(400, "mixA");
        set_timing(6, 2, 9, 1, 2);
        run_random(400, "mixB");
        set_timing(2, 11, 4, 13, 6);
        run_random(400, "mixC");

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule